// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of an external 16-bit NOR flash and turns one start request into the full chain of bus writes the device needs before it will program a word or erase a sector. It then waits for the device to finish its internal operation. It drives a plain word-write and word-read port. Each transfer is a request held until the port acknowledges it, and the port hides all bus timing from the sequencer.

The two command offsets used by the unlock chain are flash word offsets. The flash is 16 bits wide, so each offset is doubled before it goes on the byte-addressed bus. The target address is passed through as given. After the final write, the engine reads the target address again and again. It watches the status bit that toggles on every read while the device is busy. When two consecutive reads agree in that bit, the operation is over and a one-clock completion pulse is given. A parameter caps the number of status reads. If the bit is still toggling at that cap, the engine gives a one-clock error pulse instead and returns to idle.

Programming a word that was not erased first can only clear bits: the stored result is the AND of the old and new contents. The sequencer does not check the stored data; software should erase the sector first when it needs exact contents.

Top module: `nor_flash_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `busReq` are all low.
- R2: With `opSel`=0 (program), the engine issues exactly four writes as (byte address, data): (0xAAA, 0xAA), (0x554, 0x55), (0xAAA, 0xA0), then the user data to the target address.
- R3: With `opSel`=1 (erase), the engine issues exactly six writes: (0xAAA, 0xAA), (0x554, 0x55), (0xAAA, 0x80), (0xAAA, 0xAA), (0x554, 0x55), then 0x30 to the target address.
- R4: Command addresses are the word offsets 0x555 and 0x2AA shifted left by one bit. The target address goes on the bus unshifted, including odd values and high bits.
- R5: While `busReq` is high and `busAck` has not been given, `busReq`, `busWe`, `busAddr` and `busWdata` hold their values.
- R6: After the last write, the engine performs reads (`busWe`=0) of the target address. Polling needs at least two reads, and it continues for as long as bit 6 of each read differs from bit 6 of the read before it.
- R7: The first read whose bit 6 equals that of the previous read ends polling. `done` is then high for exactly one clock, `busy` is low in that same clock, and no further transfer follows.
- R8: If the read numbered POLL_LIMIT still differs from its predecessor in bit 6, `err` pulses for one clock, `done` stays low and the engine returns to idle. A match on exactly that read still gives `done`.
- R9: A `start` asserted while `busy` is high has no effect on the transfers issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| opSel | input | 1 | 0 = program word, 1 = erase sector |
| tgtAddr | input | ADDR_W | Target byte address (word or sector) |
| wrData | input | DATA_W | Word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | One-clock timeout pulse |
| busReq | output | 1 | Transfer request, held until acknowledged |
| busWe | output | 1 | 1 = write, 0 = read |
| busAddr | output | ADDR_W | Transfer byte address |
| busWdata | output | DATA_W | Write data |
| busAck | input | 1 | Transfer accepted; read data valid in this cycle |
| busRdata | input | DATA_W | Read data |

## Verification
The assertions assume that the port gives `busAck` only while `busReq` is high, as a single-cycle pulse, with `busRdata` valid in that same cycle. The bench's device model only acknowledges a pending request, and it drops the acknowledge on the following cycle before it looks at the next request. The model inserts a chosen number of wait cycles before each acknowledge so that the hold rule is exercised. It toggles bit 6 for a chosen number of reads and then holds it, which covers quick completion, completion exactly at the read cap, and runaway toggling.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } opSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch op, target and data
    logic stepClr;   // reset command step
    logic stepInc;   // advance command step
    logic rdPhase;   // bus address selects target for polling
    logic prevLoad;  // remember status bit of this read
    logic pollClr;   // clear poll read count
    logic pollInc;   // count one poll read
  } dpCtrl_t;

  localparam int unsigned STEP_W   = 3;
  localparam int unsigned WOFF_W   = 12;
  localparam logic [WOFF_W-1:0] UNLOCK_HI = 12'h555;
  localparam logic [WOFF_W-1:0] UNLOCK_LO = 12'h2AA;

  localparam logic [7:0] CMD_KEY1  = 8'hAA;
  localparam logic [7:0] CMD_KEY2  = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_SETUP = 8'h80;
  localparam logic [7:0] CMD_SECT  = 8'h30;

endpackage

// File: rtl/nor_cmd_rom.sv
module nor_cmd_rom
  import nor_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  opSel_e                     op,
  input  logic [STEP_W-1:0]          step,
  input  logic [DATA_W-1:0]          userData,
  output logic                       useTarget,
  output logic [WOFF_W-1:0]          wordOff,
  output logic [DATA_W-1:0]          cmdData,
  output logic                       lastStep
);

  localparam logic [STEP_W-1:0] PROG_LAST  = STEP_W'(3);
  localparam logic [STEP_W-1:0] ERASE_LAST = STEP_W'(5);

  logic [7:0] cmdByte;

  always_comb begin
    useTarget = 1'b0;
    wordOff   = UNLOCK_HI;
    cmdByte   = CMD_KEY1;
    cmdData   = '0;
    if (op == OP_PROG) begin
      lastStep = (step == PROG_LAST);
      case (step)
        STEP_W'(0): begin wordOff = UNLOCK_HI; cmdByte = CMD_KEY1; end
        STEP_W'(1): begin wordOff = UNLOCK_LO; cmdByte = CMD_KEY2; end
        STEP_W'(2): begin wordOff = UNLOCK_HI; cmdByte = CMD_PROG; end
        default:    begin useTarget = 1'b1;    cmdByte = 8'h00;    end
      endcase
    end else begin
      lastStep = (step == ERASE_LAST);
      case (step)
        STEP_W'(0): begin wordOff = UNLOCK_HI; cmdByte = CMD_KEY1;  end
        STEP_W'(1): begin wordOff = UNLOCK_LO; cmdByte = CMD_KEY2;  end
        STEP_W'(2): begin wordOff = UNLOCK_HI; cmdByte = CMD_SETUP; end
        STEP_W'(3): begin wordOff = UNLOCK_HI; cmdByte = CMD_KEY1;  end
        STEP_W'(4): begin wordOff = UNLOCK_LO; cmdByte = CMD_KEY2;  end
        default:    begin useTarget = 1'b1;    cmdByte = CMD_SECT;  end
      endcase
    end
    if (op == OP_PROG && useTarget) cmdData = userData;
    else                            cmdData[7:0] = cmdByte;
  end

endmodule

// File: rtl/nor_seq_dp.sv
module nor_seq_dp
  import nor_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned TOG_BIT    = 6,
  parameter int unsigned POLL_LIMIT = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic              startOp,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] startData,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              lastStep,
  output logic              togDiff,
  output logic              pollAtLimit
);

  localparam int unsigned POLL_W = $clog2(POLL_LIMIT + 1);
  localparam int unsigned CMDA_W = WOFF_W + 1;

  opSel_e             opReg;
  logic [ADDR_W-1:0]  tgtReg;
  logic [DATA_W-1:0]  usrReg;
  logic [STEP_W-1:0]  step;
  logic               prevBit;
  logic [POLL_W-1:0]  pollCnt;

  logic               useTarget;
  logic [WOFF_W-1:0]  wordOff;
  logic [DATA_W-1:0]  cmdData;
  logic [ADDR_W-1:0]  cmdAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg   <= OP_PROG;
      tgtReg  <= '0;
      usrReg  <= '0;
      step    <= '0;
      prevBit <= 1'b0;
      pollCnt <= '0;
    end else begin
      if (ctl.capture) begin
        opReg  <= opSel_e'(startOp);
        tgtReg <= startAddr;
        usrReg <= startData;
      end
      if (ctl.stepClr)      step <= '0;
      else if (ctl.stepInc) step <= step + STEP_W'(1);
      if (ctl.prevLoad) prevBit <= busRdata[TOG_BIT];
      if (ctl.pollClr)      pollCnt <= '0;
      else if (ctl.pollInc) pollCnt <= pollCnt + POLL_W'(1);
    end
  end

  nor_cmd_rom #(.DATA_W(DATA_W)) rom_i (
    .op        (opReg),
    .step      (step),
    .userData  (usrReg),
    .useTarget (useTarget),
    .wordOff   (wordOff),
    .cmdData   (cmdData),
    .lastStep  (lastStep)
  );

  // word offset to byte offset: the flash is 16 bits wide
  always_comb begin
    cmdAddr = '0;
    cmdAddr[CMDA_W-1:0] = {wordOff, 1'b0};
  end

  assign busAddr     = (ctl.rdPhase || useTarget) ? tgtReg : cmdAddr;
  assign busWdata    = cmdData;
  assign togDiff     = busRdata[TOG_BIT] ^ prevBit;
  assign pollAtLimit = (pollCnt == POLL_W'(POLL_LIMIT - 1));

  // R8: the read counter never runs past the cap
  a_r8_poll_bound: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < POLL_W'(POLL_LIMIT));

  // R9: captured request is unchanged while the step engine runs
  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.capture && !ctl.stepClr) |=> ($stable(tgtReg) && $stable(opReg)));

endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    busAck,
  input  logic    lastStep,
  input  logic    togDiff,
  input  logic    pollAtLimit,
  output dpCtrl_t ctl,
  output logic    busReq,
  output logic    busWe,
  output logic    busy,
  output logic    done,
  output logic    err
);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ1 = 2'd2,
    ST_POLL  = 2'd3
  } state_e;

  state_e state, stateNxt;
  logic   doneNxt, errNxt;

  always_comb begin
    ctl      = '0;
    busReq   = 1'b0;
    busWe    = 1'b0;
    stateNxt = state;
    doneNxt  = 1'b0;
    errNxt   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.capture = 1'b1;
          ctl.stepClr = 1'b1;
          ctl.pollClr = 1'b1;
          stateNxt    = ST_WRITE;
        end
      end
      ST_WRITE: begin
        busReq = 1'b1;
        busWe  = 1'b1;
        if (busAck) begin
          if (lastStep) stateNxt    = ST_READ1;
          else          ctl.stepInc = 1'b1;
        end
      end
      ST_READ1: begin
        busReq      = 1'b1;
        ctl.rdPhase = 1'b1;
        if (busAck) begin
          ctl.prevLoad = 1'b1;
          ctl.pollInc  = 1'b1;
          stateNxt     = ST_POLL;
        end
      end
      default: begin
        busReq      = 1'b1;
        ctl.rdPhase = 1'b1;
        if (busAck) begin
          if (!togDiff) begin
            doneNxt  = 1'b1;
            stateNxt = ST_IDLE;
          end else if (pollAtLimit) begin
            errNxt   = 1'b1;
            stateNxt = ST_IDLE;
          end else begin
            ctl.prevLoad = 1'b1;
            ctl.pollInc  = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= doneNxt;
      err   <= errNxt;
    end
  end

  assign busy = (state != ST_IDLE);

  // R7: completion is a single-clock pulse seen while idle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !busReq));
  // R7: an acknowledged poll read that matches ends the operation
  a_r7_match_ends: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busWe && busAck && ctl.pollInc == 1'b0 && !togDiff && !ctl.prevLoad && state == ST_POLL) |=> done);
  // R8: timeout and completion never coincide
  a_r8_err_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err));

endmodule

// File: rtl/nor_flash_sequencer.sv
module nor_flash_sequencer
  import nor_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned TOG_BIT    = 6,
  parameter int unsigned POLL_LIMIT = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              opSel,
  input  logic [ADDR_W-1:0] tgtAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              busReq,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busAck,
  input  logic [DATA_W-1:0] busRdata
);

  dpCtrl_t ctl;
  logic    lastStep, togDiff, pollAtLimit;

  nor_seq_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .busAck      (busAck),
    .lastStep    (lastStep),
    .togDiff     (togDiff),
    .pollAtLimit (pollAtLimit),
    .ctl         (ctl),
    .busReq      (busReq),
    .busWe       (busWe),
    .busy        (busy),
    .done        (done),
    .err         (err)
  );

  nor_seq_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .TOG_BIT    (TOG_BIT),
    .POLL_LIMIT (POLL_LIMIT)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .startOp     (opSel),
    .startAddr   (tgtAddr),
    .startData   (wrData),
    .busRdata    (busRdata),
    .busAddr     (busAddr),
    .busWdata    (busWdata),
    .lastStep    (lastStep),
    .togDiff     (togDiff),
    .pollAtLimit (pollAtLimit)
  );

  // R5: a pending transfer holds still until accepted
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busWe) && $stable(busAddr) && $stable(busWdata)));

endmodule

// File: tb/nor_flash_sequencer_tb.sv
module nor_flash_sequencer_tb_top;

  localparam int AW = 24;
  localparam int DW = 16;
  localparam int LIM = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          opSel = 1'b0;
  logic [AW-1:0] tgtAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic          busy, done, err, busReq, busWe;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWdata;
  logic          busAck = 1'b0;
  logic [DW-1:0] busRdata = '0;

  always #10 clk = ~clk;  // 50 MHz

  nor_flash_sequencer #(.ADDR_W(AW), .DATA_W(DW), .TOG_BIT(6), .POLL_LIMIT(LIM)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .tgtAddr(tgtAddr),
    .wrData(wrData), .busy(busy), .done(done), .err(err), .busReq(busReq),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .busAck(busAck),
    .busRdata(busRdata)
  );

  typedef struct {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string         req;
  } xfer_t;

  xfer_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  int doneCnt = 0;
  int errCnt  = 0;
  int togT    = 0;
  int readK   = 0;
  int latSet  = 0;
  int latCnt  = 0;
  bit holdValid = 1'b0;
  logic          hWe;
  logic [AW-1:0] hAddr;
  logic [DW-1:0] hData;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // device model and monitor: acknowledge after latSet wait cycles
  always @(negedge clk) begin
    if (!rstN) begin
      busAck = 1'b0; latCnt = 0; holdValid = 1'b0;
    end else if (busAck) begin
      busAck = 1'b0; latCnt = 0; holdValid = 1'b0;
    end else if (busReq) begin
      if (holdValid) begin
        check(hWe == busWe && hAddr == busAddr && hData == busWdata, "R5",
              "held transfer changed", {busWe, busAddr}, {hWe, hAddr});
      end
      if (latCnt >= latSet) begin
        busAck = 1'b1;
        holdValid = 1'b0;
        if (expQ.size() == 0) begin
          check(1'b0, "R9", "unexpected transfer addr", busAddr, 0);
        end else begin
          xfer_t e;
          e = expQ.pop_front();
          check(busWe == e.we && busAddr == e.addr, e.req, "transfer kind/addr",
                {busWe, busAddr}, {e.we, e.addr});
          if (e.we) check(busWdata == e.data, e.req, "write data", busWdata, e.data);
        end
        if (!busWe) begin
          int k;
          readK++;
          k = (readK < togT + 1) ? readK : togT + 1;
          busRdata = 16'h3F80 | (DW'(k & 1) << 6);
        end
      end else begin
        latCnt++;
        holdValid = 1'b1;
        hWe = busWe; hAddr = busAddr; hData = busWdata;
      end
    end
  end

  bit prevDone = 1'b0;
  bit prevErr  = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (done) begin
        doneCnt++;
        check(!busy, "R7", "busy during done", busy, 0);
        check(!prevDone, "R7", "done longer than a clock", 1, 0);
      end
      if (err) begin
        errCnt++;
        check(!prevErr, "R8", "err longer than a clock", 1, 0);
      end
      prevDone = done;
      prevErr  = err;
    end
  end

  task automatic pushW(input logic [AW-1:0] a, input logic [DW-1:0] d, input string r);
    xfer_t x;
    x.we = 1'b1; x.addr = a; x.data = d; x.req = r;
    expQ.push_back(x);
  endtask

  task automatic runOp(input logic op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input int tog, input int lat, input bit expErr, input bit poke);
    string r;
    int nRd;
    int d0, e0;
    r = op ? "R3" : "R2";
    pushW(24'hAAA, 16'h00AA, "R4");
    pushW(24'h554, 16'h0055, "R4");
    if (op) begin
      pushW(24'hAAA, 16'h0080, r);
      pushW(24'hAAA, 16'h00AA, r);
      pushW(24'h554, 16'h0055, r);
      pushW(a, 16'h0030, "R4");
    end else begin
      pushW(24'hAAA, 16'h00A0, r);
      pushW(a, d, "R4");
    end
    nRd = expErr ? LIM : tog + 2;
    for (int i = 0; i < nRd; i++) begin
      xfer_t x;
      x.we = 1'b0; x.addr = a; x.data = '0; x.req = "R6";
      expQ.push_back(x);
    end
    togT = tog; readK = 0; latSet = lat;
    d0 = doneCnt; e0 = errCnt;
    @(negedge clk);
    start = 1'b1; opSel = op; tgtAddr = a; wrData = d;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; opSel = ~op; tgtAddr = a ^ 24'h000040; wrData = ~d;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, poke ? "R9" : r, "transfers left over", expQ.size(), 0);
    check(readK == nRd, "R6", "poll read count", readK, nRd);
    if (expErr) begin
      check(errCnt - e0 == 1, "R8", "err pulses", errCnt - e0, 1);
      check(doneCnt - d0 == 0, "R8", "done on timeout", doneCnt - d0, 0);
    end else begin
      check(doneCnt - d0 == 1, "R7", "done pulses", doneCnt - d0, 1);
      check(errCnt - e0 == 0, "R8", "err without timeout", errCnt - e0, 0);
    end
    expQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !err && !busReq, "R1", "reset outputs",
          {busy, done, err, busReq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !busReq, "R1", "idle after reset", {busy, busReq}, 0);
    runOp(1'b0, 24'h000100, 16'h1234, 0, 0, 1'b0, 1'b0); // program, settles at once
    runOp(1'b1, 24'h080000, 16'h0000, 3, 2, 1'b0, 1'b0); // erase with waits
    runOp(1'b0, 24'hF00003, 16'hBEEF, 2, 1, 1'b0, 1'b0); // odd, high target
    runOp(1'b0, 24'h000200, 16'h0047, LIM - 2, 0, 1'b0, 1'b0); // match on last read
    runOp(1'b1, 24'h010000, 16'h0000, 20, 0, 1'b1, 1'b0); // runaway toggle
    runOp(1'b0, 24'h000300, 16'hA5A5, 4, 1, 1'b0, 1'b1); // start while busy
    runOp(1'b1, 24'h020000, 16'h0000, 1, 3, 1'b0, 1'b1);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule